// File: doc/BRIEF.md
# Buzzer Tone Generator

This block drives a single buzzer pin from a low-speed clock of nominally 32.768 kHz. A start pulse captures a tone pitch (one of eight), a 4-bit duty setting and a sound mode, and the tone then plays under an on/off envelope. There are four envelopes: endless tone, one timed beep, a regular half-and-half pattern, and a double-chirp pattern followed by a long pause. A stop pulse ends the sound at any time.

After a single beep ends by itself, a done flag is raised. That flag stays set until the next start. An output polarity input sets which level means "sounding". The same input sets the level the pin rests at when the block is silent.

Envelope timing is counted in beats of `BEAT_CYCLES` clocks. The default of 2048 gives 62.5 ms at 32.768 kHz.

Top module: `buzz_gen`

## Requirements
- R1: After reset, run_o and done_o are 0 and buzz_o equals pol_neg_i.
- R2: A start_i pulse captures mode_i, freq_sel_i and duty_i, sets run_o and clears done_o at the next edge. The tone and the envelope begin at their first cycle. start_i overrides a stop_i pulse and a beep expiry that fall in the same cycle.
- R3: A stop_i pulse without start_i clears run_o at the next edge. The pin then sits at its inactive level.
- R4: The tone period in clock cycles is selected by freq_sel_i. Codes 0 to 7 give 8, 10, 12, 14, 16, 32, 64 and 112 cycles.
- R5: Each tone period opens with a high phase of H cycles, where H = floor((P*d + 8)/16), d is duty_i, and a duty_i of 0 counts as 1. H is capped at P-1.
- R6: pol_neg_i = 0 makes the active level 1. pol_neg_i = 1 inverts buzz_o at all times, including while idle. The input takes effect live and is not captured.
- R7: mode_i = 0 (continuous) sounds without end until stopped.
- R8: mode_i = 1 (single) sounds for 2 beats and then clears run_o by itself. done_o rises at the same edge and holds until the next start.
- R9: mode_i = 2 repeats 2 beats of sound followed by 2 beats of silence.
- R10: mode_i = 3 repeats an 11-beat cycle: 1 beat on, 1 off, 1 on, then 8 off.
- R11: The tone phase runs on through silent beats. At every cycle of a run, the phase equals the cycles since start modulo P.
- R12: Changes on mode_i, freq_sel_i or duty_i during a run have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures configuration |
| stop_i | input | 1 | Stop pulse |
| mode_i | input | 2 | Envelope: 0 continuous, 1 single, 2 pattern A, 3 pattern B |
| freq_sel_i | input | 3 | Tone pitch code |
| duty_i | input | 4 | Duty in sixteenths |
| pol_neg_i | input | 1 | 1 selects active-low output |
| run_o | output | 1 | Sound running |
| done_o | output | 1 | Single beep finished |
| buzz_o | output | 1 | Buzzer pin |

## Verification
The tightest collision is a single beep's natural expiry landing in the same cycle as a fresh start pulse. In that case the start must win: done_o stays clear and a new beep begins. The bench counts exactly 2*BEAT_CYCLES-1 edges after a start before pulsing start again, which provokes this cycle. A second collision, start and stop asserted together, is provoked in the same way. A behavioural model derives the expected run, done and pin values from elapsed cycles alone, and those values are compared on every clock.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic [1:0] {
    MODE_CONT   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_INT1   = 2'd2,
    MODE_INT2   = 2'd3
  } buzz_mode_e;

  localparam int unsigned TONE_W = 7;
  localparam int unsigned PROD_W = TONE_W + 5;

  function automatic logic [TONE_W-1:0] tone_period(input logic [2:0] sel);
    logic [TONE_W-1:0] p;
    case (sel)
      3'd0:    p = TONE_W'(8);
      3'd1:    p = TONE_W'(10);
      3'd2:    p = TONE_W'(12);
      3'd3:    p = TONE_W'(14);
      3'd4:    p = TONE_W'(16);
      3'd5:    p = TONE_W'(32);
      3'd6:    p = TONE_W'(64);
      default: p = TONE_W'(112);
    endcase
    return p;
  endfunction

  // round-half-up of per*duty/16, duty 0 read as 1, capped below per
  function automatic logic [TONE_W-1:0] tone_high(input logic [TONE_W-1:0] per,
                                                  input logic [3:0] duty);
    logic [3:0]        d;
    logic [PROD_W-1:0] prod;
    logic [TONE_W-1:0] h;
    d    = (duty == 4'd0) ? 4'd1 : duty;
    prod = PROD_W'(per) * PROD_W'(d) + PROD_W'(8);
    h    = prod[TONE_W+3:4];
    if (h >= per) h = per - 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/buzz_tone.sv
module buzz_tone
  import buzz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic [2:0] freq_sel_i,
  input  logic [3:0] duty_i,
  output logic       tone_o
);
  logic [TONE_W-1:0] per_q, high_q, cnt_q;
  logic [TONE_W-1:0] per_new;

  assign per_new = tone_period(freq_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= TONE_W'(8);
      high_q <= TONE_W'(1);
      cnt_q  <= '0;
    end else if (restart_i) begin
      per_q  <= per_new;
      high_q <= tone_high(per_new, duty_i);
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q  <= (cnt_q == per_q - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tone_o = cnt_q < high_q;

  p_cnt_in_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < per_q);
  p_tone_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i && cnt_q == per_q - 1'b1 |=> cnt_q == '0);
  p_high_bounds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> high_q != '0 && high_q < per_q);
endmodule

// File: rtl/buzz_pattern.sv
module buzz_pattern
  import buzz_pkg::*;
#(
  parameter int unsigned BEAT_CYCLES = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] mode_i,
  output logic       run_o,
  output logic       done_o,
  output logic       gate_o
);
  localparam int unsigned BEAT_W     = $clog2(BEAT_CYCLES);
  localparam int unsigned SINGLE_LEN = 2;
  localparam int unsigned INT1_LEN   = 4;
  localparam int unsigned INT1_ON    = 2;
  localparam int unsigned INT2_LEN   = 11;
  localparam int unsigned INT2_ON2   = 2;
  localparam int unsigned UNIT_W     = $clog2(INT2_LEN);

  buzz_mode_e        mode_q;
  logic [BEAT_W-1:0] beat_q;
  logic [UNIT_W-1:0] unit_q;
  logic              run_q, done_q;
  logic              beat_last, unit_last, expire;

  assign beat_last = beat_q == BEAT_W'(BEAT_CYCLES - 1);

  always_comb begin
    case (mode_q)
      MODE_SINGLE: unit_last = unit_q == UNIT_W'(SINGLE_LEN - 1);
      MODE_INT1:   unit_last = unit_q == UNIT_W'(INT1_LEN - 1);
      MODE_INT2:   unit_last = unit_q == UNIT_W'(INT2_LEN - 1);
      default:     unit_last = 1'b0;
    endcase
  end

  always_comb begin
    case (mode_q)
      MODE_INT1: gate_o = unit_q < UNIT_W'(INT1_ON);
      MODE_INT2: gate_o = (unit_q == '0) || (unit_q == UNIT_W'(INT2_ON2));
      default:   gate_o = 1'b1;
    endcase
  end

  assign expire = run_q && mode_q == MODE_SINGLE && beat_last && unit_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_CONT;
      beat_q <= '0;
      unit_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      mode_q <= buzz_mode_e'(mode_i);
      beat_q <= '0;
      unit_q <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (expire) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
      if (stop_i) run_q <= 1'b0;
      if (run_q) begin
        if (beat_last) begin
          beat_q <= '0;
          if (mode_q != MODE_CONT) unit_q <= unit_last ? '0 : unit_q + 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;

  p_start_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_q && !done_q);
  p_stop_halts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !run_q);
  p_cont_endless_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && mode_q == MODE_CONT && !stop_i && !start_i |=> run_q);
  p_done_after_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(run_q) && $past(mode_q) == MODE_SINGLE);
  p_unit_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_q < UNIT_W'(INT2_LEN));
endmodule

// File: rtl/buzz_gen.sv
module buzz_gen
  import buzz_pkg::*;
#(
  parameter int unsigned BEAT_CYCLES = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] mode_i,
  input  logic [2:0] freq_sel_i,
  input  logic [3:0] duty_i,
  input  logic       pol_neg_i,
  output logic       run_o,
  output logic       done_o,
  output logic       buzz_o
);
  logic run, gate, tone;

  buzz_pattern #(.BEAT_CYCLES(BEAT_CYCLES)) u_pattern (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .mode_i  (mode_i),
    .run_o   (run),
    .done_o  (done_o),
    .gate_o  (gate)
  );

  buzz_tone u_tone (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (start_i),
    .run_i      (run),
    .freq_sel_i (freq_sel_i),
    .duty_i     (duty_i),
    .tone_o     (tone)
  );

  assign run_o  = run;
  assign buzz_o = (run && gate && tone) ^ pol_neg_i;

  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> buzz_o == pol_neg_i);
  p_gap_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !gate |-> buzz_o == pol_neg_i);
endmodule

// File: tb/buzz_gen_bench.sv
module buzz_gen_bench;
  localparam int BEAT = 2048;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0] mode = '0;
  logic [2:0] fsel = '0;
  logic [3:0] duty = '0;
  logic       pol = 1'b0;
  logic       run_o, done_o, buzz_o;

  buzz_gen #(.BEAT_CYCLES(BEAT)) u_buzz_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .mode_i(mode), .freq_sel_i(fsel), .duty_i(duty), .pol_neg_i(pol),
    .run_o(run_o), .done_o(done_o), .buzz_o(buzz_o)
  );

  always #4 clk = ~clk;

  int    checks = 0, errors = 0;
  string req = "R1";

  int m_run = 0, m_done = 0, m_k = 0, m_mode = 0, m_per = 8, m_hi = 1;

  function automatic int per_of(int s);
    case (s)
      0: return 8;   1: return 10;  2: return 12;  3: return 14;
      4: return 16;  5: return 32;  6: return 64;  default: return 112;
    endcase
  endfunction

  function automatic int hi_of(int p, int d);
    int dd = (d == 0) ? 1 : d;
    int h  = (p * dd + 8) / 16;
    if (h >= p) h = p - 1;
    return h;
  endfunction

  function automatic int on_of(int md, int k);
    int u = k / BEAT;
    case (md)
      2:       return ((u % 4) < 2) ? 1 : 0;
      3:       return ((u % 11) == 0 || (u % 11) == 2) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  // reference model: state from cycles elapsed since start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_k = 0;
    end else if (start) begin
      m_run = 1; m_done = 0; m_k = 0; m_mode = mode;
      m_per = per_of(fsel); m_hi = hi_of(m_per, duty);
    end else begin
      if (m_run != 0) begin
        if (m_mode == 1 && m_k == 2 * BEAT - 1) begin m_run = 0; m_done = 1; end
        else m_k = m_k + 1;
      end
      if (stop) m_run = 0;
    end
  end

  function automatic int exp_bz();
    int a = (m_run != 0 && on_of(m_mode, m_k) != 0 && (m_k % m_per) < m_hi) ? 1 : 0;
    return a ^ int'(pol);
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req, "run_o", int'(run_o), m_run);
      chk(req, "done_o", int'(done_o), m_done);
      chk(req, "buzz_o", int'(buzz_o), exp_bz());
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go(int md, int f, int d);
    mode = 2'(md); fsel = 3'(f); duty = 4'(d); start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic halt();
    stop = 1'b1; tick(1); stop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk("R1", "run_o reset", int'(run_o), 0);
    chk("R1", "done_o reset", int'(done_o), 0);
    chk("R1", "buzz_o reset", int'(buzz_o), 0);
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R7 R4 R5: continuous tone across all pitches and several duties
    req = "R4_R5_R7";
    for (int f = 0; f < 8; f++) begin
      go(0, f, (f * 5) % 16);
      tick(250);
      go(0, f, 15);
      tick(250);
    end
    go(0, 0, 0);
    tick(40);

    // R6: live polarity, running and idle
    req = "R6";
    pol = 1'b1; tick(30);
    pol = 1'b0; tick(30);

    // R3: stop
    req = "R3";
    halt(); tick(20);
    pol = 1'b1; tick(10);
    @(negedge clk);
    chk("R3", "buzz_o idle inactive", int'(buzz_o), 1);
    tick(1);
    pol = 1'b0;

    // R12: config changes mid-run ignored
    req = "R12";
    go(0, 2, 5); tick(100);
    mode = 2'd3; fsel = 3'd7; duty = 4'd1; tick(300);
    halt(); tick(5);

    // R2: start with stop in same cycle
    req = "R2";
    mode = 2'd0; fsel = 3'd1; duty = 4'd8; start = 1'b1; stop = 1'b1;
    tick(1); start = 1'b0; stop = 1'b0;
    @(negedge clk);
    chk("R2", "run_o start beats stop", int'(run_o), 1);
    tick(1); tick(20);
    halt();

    // R8: single beep
    req = "R8";
    go(1, 4, 8);
    tick(2 * BEAT + 50);
    @(negedge clk);
    chk("R8", "done_o after beep", int'(done_o), 1);
    chk("R8", "run_o after beep", int'(run_o), 0);
    tick(1);

    // R2 R8: restart lands exactly on expiry edge
    req = "R2_R8";
    go(1, 3, 4);
    tick(2 * BEAT - 1);
    start = 1'b1; tick(1); start = 1'b0;
    @(negedge clk);
    chk("R2", "done_o clear on restart at expiry", int'(done_o), 0);
    chk("R2", "run_o set on restart at expiry", int'(run_o), 1);
    tick(1);
    tick(2 * BEAT + 10);

    // R9 R11: pattern A
    req = "R9_R11";
    go(2, 5, 6);
    tick(4 * BEAT * 2 + 30);
    halt();

    // R10 R11: pattern B with inverted polarity
    req = "R10_R11";
    pol = 1'b1;
    go(3, 6, 11);
    tick(11 * BEAT + 3 * BEAT);
    halt(); tick(10);
    pol = 1'b0;
    tick(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule